// File: doc/BRIEF.md
# PWM Output Action Qualifier with Software Force

This block sets the levels of two PWM outputs, A and B. A time base and compare logic outside the block supply single-cycle event strobes: counter at zero, counter at period, compare-A match while counting up, and compare-B match while counting up. A strobe counts only in a cycle where the time-base tick enable is high. Each channel has a 16-bit action word. For every event this word holds a 2-bit code that leaves the output alone, drives it low, drives it high or toggles it. When several events land on the same tick, one fixed priority picks the action that applies.

Software can also hold either output at a fixed level through a continuous-force word. This word is a shadow copy. Its value moves into the active force register only at a reload point chosen by a 2-bit selector: counter zero, period match, either of the two, or every tick (immediate). While the active force code for a channel is low or high, it overrides every event action on that channel.

Top module: `pwm_action_shaper`

## Requirements
- R1: After reset both outputs are low and the active force register holds 0 (no force). A nonzero shadow force value has no effect until a reload point occurs.
- R2: Action codes are 0 = no change, 1 = drive low, 2 = drive high, 3 = toggle. The code is applied on a tick where its event is asserted.
- R3: In the action word, the zero-event code sits at bits 1:0, the period code at bits 3:2, the compare-A up code at bits 5:4 and the compare-B up code at bits 9:8. Bits 7:6 and 15:10 have no effect.
- R4: When several events fall on one tick, the highest-priority asserted event whose code is nonzero decides the action. The order from highest to lowest is compare-B, compare-A, period, zero.
- R5: When the tick enable is low, neither the outputs nor the active force register change, whatever the event inputs do.
- R6: Channel A's force code is at bits 1:0 of the force word and channel B's at bits 3:2. Active code 1 holds the output low and code 2 holds it high, overriding all event actions. Codes 0 and 3 apply no force.
- R7: With reload selector 0, the shadow force word is copied to the active register only on a tick that carries a zero event.
- R8: With reload selector 1, the copy happens only on a tick that carries a period event.
- R9: With reload selector 2, the copy happens on a tick that carries a zero event or a period event.
- R10: With reload selector 3, the copy happens on every tick. A newly written force value therefore sets the output from the next tick, even when no event occurs.
- R11: With zero and period programmed to drive high and compare up to drive low, each output is a PWM wave. It is high from the zero event until the compare match of its own channel.
- R12: When the force is released (code 0 made active), the output keeps its forced level until a later event action changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base clock enable; events and reloads act only when high |
| evt_zero | input | 1 | Counter reached zero |
| evt_period | input | 1 | Counter reached period |
| evt_cmpa_up | input | 1 | Compare-A match while counting up |
| evt_cmpb_up | input | 1 | Compare-B match while counting up |
| act_ctl_a | input | 16 | Action word for channel A |
| act_ctl_b | input | 16 | Action word for channel B |
| force_reload_sel | input | 2 | Force reload point: 0 zero, 1 period, 2 either, 3 immediate |
| force_ctl | input | 4 | Shadow continuous-force word |
| pwm_out | output | 2 | Channel outputs, bit 0 = A, bit 1 = B |

## Verification
The event logic is driven three ways: with single events for each code and field, which separates the meaning of the codes and the position of each field; with coincident events under mixed codes, which exposes the priority order and the fall-through past zero codes; and with a full up-count sweep, where each compare point must shape a PWM wave. Each of the four reload selectors is run with events placed before and at its reload point, so that a load made too early or too late is visible at the outputs. Strobes with the tick enable low, and codes 0 and 3 in the force word, confirm that these inputs leave the outputs untouched.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int unsigned CODE_W     = 2;
  localparam int unsigned POS_ZERO   = 0;
  localparam int unsigned POS_PERIOD = 2;
  localparam int unsigned POS_CMPA   = 4;
  localparam int unsigned POS_CMPB   = 8;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'd0,
    RLD_PERIOD = 2'd1,
    RLD_EITHER = 2'd2,
    RLD_NOW    = 2'd3
  } reload_e;

  // Pick the action of the highest-priority present event with a nonzero code.
  function automatic act_e pick_action(input act_e c_zero, input act_e c_prd,
                                       input act_e c_cma, input act_e c_cmb,
                                       input logic z, input logic p,
                                       input logic ca, input logic cb);
    act_e r;
    r = ACT_NONE;
    if (z  && c_zero != ACT_NONE) r = c_zero;
    if (p  && c_prd  != ACT_NONE) r = c_prd;
    if (ca && c_cma  != ACT_NONE) r = c_cma;
    if (cb && c_cmb  != ACT_NONE) r = c_cmb;
    return r;
  endfunction

  function automatic logic apply_action(input logic cur, input act_e a);
    logic n;
    case (a)
      ACT_LOW:    n = 1'b0;
      ACT_HIGH:   n = 1'b1;
      ACT_TOGGLE: n = ~cur;
      default:    n = cur;
    endcase
    return n;
  endfunction

  function automatic logic reload_due(input reload_e sel, input logic z, input logic p);
    logic d;
    case (sel)
      RLD_ZERO:   d = z;
      RLD_PERIOD: d = p;
      RLD_EITHER: d = z | p;
      default:    d = 1'b1;
    endcase
    return d;
  endfunction

  // Force codes 1 and 2 hold the level; 0 and 3 leave the event result.
  function automatic logic shape_level(input logic [CODE_W-1:0] frc, input logic ev_level);
    logic n;
    case (frc)
      2'd1:    n = 1'b0;
      2'd2:    n = 1'b1;
      default: n = ev_level;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/aq_event_select.sv
module aq_event_select
  import pwm_aq_pkg::*;
#(
  parameter int unsigned CTL_W = 16
) (
  input  logic [CTL_W-1:0] ctl,
  input  logic             tick,
  input  logic             evt_zero,
  input  logic             evt_period,
  input  logic             evt_cmpa_up,
  input  logic             evt_cmpb_up,
  output act_e             act
);
  act_e c_zero, c_prd, c_cma, c_cmb;

  assign c_zero = act_e'(ctl[POS_ZERO   +: CODE_W]);
  assign c_prd  = act_e'(ctl[POS_PERIOD +: CODE_W]);
  assign c_cma  = act_e'(ctl[POS_CMPA   +: CODE_W]);
  assign c_cmb  = act_e'(ctl[POS_CMPB   +: CODE_W]);

  // Reserved bits of the action word carry no meaning.
  logic unused_ctl_bits;
  assign unused_ctl_bits = ^{ctl[CTL_W-1:POS_CMPB+CODE_W], ctl[POS_CMPA+CODE_W +: 2]};

  always_comb begin
    if (tick)
      act = pick_action(c_zero, c_prd, c_cma, c_cmb,
                        evt_zero, evt_period, evt_cmpa_up, evt_cmpb_up);
    else
      act = ACT_NONE;
  end
endmodule

// File: rtl/aq_force_shadow.sv
module aq_force_shadow
  import pwm_aq_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned FRC_W = NUM_CH * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             evt_zero,
  input  logic             evt_period,
  input  logic [1:0]       reload_sel,
  input  logic [FRC_W-1:0] shadow,
  output logic [FRC_W-1:0] active,
  output logic             load,
  output logic [FRC_W-1:0] effective
);
  assign load      = tick & reload_due(reload_e'(reload_sel), evt_zero, evt_period);
  // The force value in use on this tick: the incoming value when it loads now.
  assign effective = load ? shadow : active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active <= '0;
    else if (load) active <= shadow;
  end
endmodule

// File: rtl/aq_channel_out.sv
module aq_channel_out
  import pwm_aq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  act_e              act,
  input  logic [CODE_W-1:0] frc,
  output logic              level
);
  logic nxt;

  always_comb begin
    if (tick) nxt = shape_level(frc, apply_action(level, act));
    else      nxt = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= 1'b0;
    else        level <= nxt;
  end
endmodule

// File: rtl/pwm_action_shaper.sv
module pwm_action_shaper
  import pwm_aq_pkg::*;
#(
  parameter int unsigned CTL_W  = 16,
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned FRC_W = NUM_CH * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              evt_cmpa_up,
  input  logic              evt_cmpb_up,
  input  logic [CTL_W-1:0]  act_ctl_a,
  input  logic [CTL_W-1:0]  act_ctl_b,
  input  logic [1:0]        force_reload_sel,
  input  logic [FRC_W-1:0]  force_ctl,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [CTL_W-1:0] ctl_arr [NUM_CH];
  act_e             ch_act  [NUM_CH];
  logic [FRC_W-1:0] force_act;
  logic [FRC_W-1:0] eff_force;
  logic             force_load;

  assign ctl_arr[0] = act_ctl_a;
  assign ctl_arr[1] = act_ctl_b;

  aq_force_shadow #(.NUM_CH(NUM_CH)) u_force (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .evt_zero   (evt_zero),
    .evt_period (evt_period),
    .reload_sel (force_reload_sel),
    .shadow     (force_ctl),
    .active     (force_act),
    .load       (force_load),
    .effective  (eff_force)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    aq_event_select #(.CTL_W(CTL_W)) u_sel (
      .ctl         (ctl_arr[ch]),
      .tick        (tick),
      .evt_zero    (evt_zero),
      .evt_period  (evt_period),
      .evt_cmpa_up (evt_cmpa_up),
      .evt_cmpb_up (evt_cmpb_up),
      .act         (ch_act[ch])
    );

    aq_channel_out u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .act   (ch_act[ch]),
      .frc   (eff_force[ch*CODE_W +: CODE_W]),
      .level (pwm_out[ch])
    );
  end
endmodule

// File: rtl/pwm_action_shaper_chk.sv
module pwm_action_shaper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       evt_zero,
  input logic       evt_period,
  input logic [1:0] force_reload_sel,
  input logic [3:0] force_ctl,
  input logic [3:0] force_act,
  input logic [3:0] eff_force,
  input logic [1:0] pwm_out
);
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm_out));

  a_r5_force_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(force_act));

  a_r6_force_low_a: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eff_force[1:0] == 2'd1) |=> !pwm_out[0]);

  a_r6_force_high_b: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eff_force[3:2] == 2'd2) |=> pwm_out[1]);

  a_r7_zero_reload_only: assert property (@(posedge clk) disable iff (!rst_n)
    (force_reload_sel == 2'd0 && !(tick && evt_zero)) |=> $stable(force_act));

  a_r8_period_reload_only: assert property (@(posedge clk) disable iff (!rst_n)
    (force_reload_sel == 2'd1 && !(tick && evt_period)) |=> $stable(force_act));

  a_r9_either_reload_only: assert property (@(posedge clk) disable iff (!rst_n)
    (force_reload_sel == 2'd2 && !(tick && (evt_zero || evt_period))) |=> $stable(force_act));

  a_r10_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_reload_sel == 2'd3) |=> force_act == $past(force_ctl));
endmodule

bind pwm_action_shaper pwm_action_shaper_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .tick             (tick),
  .evt_zero         (evt_zero),
  .evt_period       (evt_period),
  .force_reload_sel (force_reload_sel),
  .force_ctl        (force_ctl),
  .force_act        (force_act),
  .eff_force        (eff_force),
  .pwm_out          (pwm_out)
);

// File: tb/tb_pwm_action_shaper.sv
module tb_pwm_action_shaper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        evt_zero = 1'b0, evt_period = 1'b0, evt_cmpa_up = 1'b0, evt_cmpb_up = 1'b0;
  logic [15:0] act_ctl_a = '0, act_ctl_b = '0;
  logic [1:0]  force_reload_sel = '0;
  logic [3:0]  force_ctl = '0;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_action_shaper dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .evt_zero(evt_zero), .evt_period(evt_period),
    .evt_cmpa_up(evt_cmpa_up), .evt_cmpb_up(evt_cmpb_up),
    .act_ctl_a(act_ctl_a), .act_ctl_b(act_ctl_b),
    .force_reload_sel(force_reload_sel), .force_ctl(force_ctl),
    .pwm_out(pwm_out)
  );

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (pwm_out !== exp) begin
      errors++;
      $display("FAIL %s: pwm_out=%b expected=%b at %0t", req, pwm_out, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [3:0] frc, input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0;
    {evt_zero, evt_period, evt_cmpa_up, evt_cmpb_up} = '0;
    act_ctl_a = '0; act_ctl_b = '0;
    force_ctl = frc; force_reload_sel = sel;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One tick carrying the given events; outputs are read at the following falling edge.
  task automatic pulse(input logic z, input logic p, input logic ca, input logic cb);
    @(negedge clk);
    {evt_zero, evt_period, evt_cmpa_up, evt_cmpb_up} = {z, p, ca, cb};
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    {evt_zero, evt_period, evt_cmpa_up, evt_cmpb_up} = '0;
  endtask

  task automatic t_reset;
    do_reset(4'b0101, 2'd0);
    check("R1 reset low", 2'b00);
    act_ctl_a = 16'h0008; act_ctl_b = 16'h0008;
    pulse(0, 1, 0, 0);
    check("R1 shadow force inactive", 2'b11);
    act_ctl_a = 16'h0000; act_ctl_b = 16'h0000;
    pulse(1, 0, 0, 0);
    check("R7 zero loads shadow low force", 2'b00);
  endtask

  task automatic t_codes;
    do_reset(4'b0000, 2'd0);
    act_ctl_a = 16'h0002;                  // zero -> high
    act_ctl_b = 16'h0300;                  // cmpB up -> toggle
    pulse(1, 0, 0, 0);
    check("R2 zero drive high", 2'b01);
    pulse(0, 0, 0, 1);
    check("R2 toggle up", 2'b11);
    pulse(0, 0, 0, 1);
    check("R2 toggle down", 2'b01);
    act_ctl_a = 16'h0004;                  // period -> low
    pulse(0, 1, 0, 0);
    check("R3 period field drive low", 2'b00);
    act_ctl_a = 16'h0020;                  // cmpA up -> high
    pulse(0, 0, 1, 0);
    check("R3 compare-A field", 2'b01);
    act_ctl_a = 16'hFCC0;                  // only reserved bits set
    act_ctl_b = 16'hFCC0;
    pulse(1, 1, 1, 1);
    check("R3 reserved bits ignored", 2'b01);
    act_ctl_a = 16'h0000; act_ctl_b = 16'h0000;
    pulse(1, 1, 1, 1);
    check("R2 code 0 no change", 2'b01);
  endtask

  task automatic t_notick;
    do_reset(4'b0000, 2'd3);
    act_ctl_a = 16'h0002; act_ctl_b = 16'h0002;
    @(negedge clk);
    {evt_zero, evt_period, evt_cmpa_up, evt_cmpb_up} = 4'b1111;
    force_ctl = 4'b1010;
    repeat (4) @(negedge clk);
    {evt_zero, evt_period, evt_cmpa_up, evt_cmpb_up} = '0;
    force_ctl = 4'b0000;
    check("R5 events and force ignored without tick", 2'b00);
    pulse(1, 0, 0, 0);
    check("R5 active force untouched without tick", 2'b11);
  endtask

  task automatic t_priority;
    do_reset(4'b0000, 2'd0);
    // zero->high, period->low, cmpA->high, cmpB->low
    act_ctl_a = 16'h0126;
    pulse(1, 1, 1, 1);
    check("R4 compare-B wins", 2'b00);
    pulse(1, 1, 1, 0);
    check("R4 compare-A over period", 2'b01);
    pulse(1, 1, 0, 0);
    check("R4 period over zero", 2'b00);
    pulse(1, 0, 0, 0);
    check("R4 zero alone", 2'b01);
    pulse(0, 1, 0, 0);
    check("R4 period alone", 2'b00);
    act_ctl_a = 16'h0002;
    pulse(1, 1, 1, 1);
    check("R4 falls through zero codes", 2'b01);
  endtask

  task automatic t_pwm;
    int period_v = 9;
    int cmp_a = 3;
    int cmp_b = 6;
    logic [1:0] exp = 2'b00;
    int bad = 0;
    do_reset(4'b0000, 2'd0);
    act_ctl_a = 16'h001A;
    act_ctl_b = 16'h010A;
    for (int n = 0; n < 3 * (period_v + 1); n++) begin
      int cnt = n % (period_v + 1);
      logic z = (cnt == 0);
      logic p = (cnt == period_v);
      logic ca = (cnt == cmp_a);
      logic cb = (cnt == cmp_b);
      if (z || p) exp = 2'b11;
      if (ca) exp[0] = 1'b0;
      if (cb) exp[1] = 1'b0;
      pulse(z, p, ca, cb);
      if (pwm_out !== exp) bad++;
      check("R11 up-count PWM wave", exp);
    end
  endtask

  task automatic t_force_zero;
    do_reset(4'b0000, 2'd0);
    act_ctl_a = 16'h001A; act_ctl_b = 16'h010A;
    pulse(1, 0, 0, 0);
    check("R7 setup both high", 2'b11);
    force_ctl = 4'b1001;                   // A low, B high
    pulse(0, 0, 1, 1);
    check("R7 no load before zero", 2'b00);
    pulse(1, 0, 0, 0);
    check("R6 force A low B high at zero", 2'b10);
    pulse(0, 0, 1, 1);
    check("R6 force overrides compare", 2'b10);
    force_ctl = 4'b1111;
    act_ctl_a = 16'h0002; act_ctl_b = 16'h0001;
    pulse(1, 0, 0, 0);
    check("R6 code 3 applies no force", 2'b01);
  endtask

  task automatic t_force_period;
    do_reset(4'b0010, 2'd1);
    act_ctl_a = 16'h0001;
    pulse(1, 0, 0, 0);
    check("R8 zero does not load", 2'b00);
    pulse(0, 1, 0, 0);
    check("R8 period loads force high", 2'b01);
  endtask

  task automatic t_force_either;
    do_reset(4'b0010, 2'd2);
    pulse(0, 0, 1, 1);
    check("R9 compare does not load", 2'b00);
    pulse(1, 0, 0, 0);
    check("R9 zero loads", 2'b01);
    force_ctl = 4'b0001;
    pulse(0, 0, 1, 0);
    check("R9 held until reload point", 2'b01);
    pulse(0, 1, 0, 0);
    check("R9 period loads", 2'b00);
  endtask

  task automatic t_force_now;
    do_reset(4'b0000, 2'd3);
    act_ctl_a = 16'h0010;                  // cmpA up -> low
    force_ctl = 4'b0010;
    repeat (3) @(negedge clk);
    check("R10 no tick no change", 2'b00);
    pulse(0, 0, 0, 0);
    check("R10 immediate force on next tick", 2'b01);
    force_ctl = 4'b0000;
    pulse(0, 0, 0, 0);
    check("R12 release keeps level", 2'b01);
    pulse(0, 0, 1, 0);
    check("R12 event resumes control", 2'b00);
  endtask

  initial begin
    t_reset();
    t_codes();
    t_notick();
    t_priority();
    t_pwm();
    t_force_zero();
    t_force_period();
    t_force_either();
    t_force_now();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule